// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the register front end of a peripheral DMA channel. It holds four 32-bit words that a processor reaches through a simple write/read port with a byte address: a control and status word, a transfer address word, and two general-purpose words. The block carries no data and translates no addresses. It keeps the channel's control state and reports events from the attached peripheral and from the transfer engine.

Writes to the control word are reshaped before they are stored. The top nibble always holds a fixed version code. A drain request clears itself. An all-zero write turns into a drain request. A control write with the device-reset bit set sends a one-cycle reset pulse to the attached device. A write to the address word marks the channel as loaded in the control word.

The peripheral's interrupt request is followed edge by edge into a status bit and an interrupt output. A completion strobe from the transfer engine carries a byte count, which moves the address word forward.

Top module: `dma_regblk`

## Requirements
- R1: After synchronous reset, word 0 reads 0xA0000000, words 1 to 3 read 0, and `irq_out` and `dev_reset` are low.
- R2: Address bits [3:2] select the word (0 control, 1 address, 2 and 3 general). All other address bits are ignored for both writes and reads.
- R3: A write to word 0 stores the rewritten value ANDed with 0x0FFFFFFF and then ORed with VERSION placed in bits [31:28] (default 0xA).
- R4: A word 0 write with bit 7 clear and bit 6 (drain) set is stored with bit 6 cleared.
- R5: A word 0 write of exactly zero is stored as 0xA0000040.
- R6: A word 0 write with bit 7 set drives `dev_reset` high for exactly the one cycle after the write. Bit 6 of that write is stored unchanged.
- R7: A word 0 write with bit 4 (interrupt enable) clear drives `irq_out` low from the next cycle, unless a peripheral request edge arrives in the same cycle.
- R8: A write to word 1 stores the written value and sets bit 26 (loaded) of word 0 in the next cycle.
- R9: A rising edge on `periph_irq` sets bit 0 of word 0 and raises `irq_out` in the next cycle. A falling edge clears both in the next cycle.
- R10: A `xfer_done` strobe adds `xfer_bytes` to word 1, modulo 2^32, and sets bit 0 of word 0. It leaves `irq_out` unchanged.
- R11: When a bus write to word 1 and a `xfer_done` strobe fall in the same cycle, word 1 takes the written value. The strobe is dropped entirely: no increment, and bit 0 is not set.
- R12: A read strobe returns the addressed word on `bus_rdata` in the next cycle and changes no state. `bus_rdata` holds its value while no read is issued.
- R13: Words 2 and 3 store any written value independently of each other and of words 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| periph_irq | input | 1 | Interrupt request level from the attached peripheral |
| xfer_done | input | 1 | Transfer completion strobe |
| xfer_bytes | input | CNT_W | Byte count carried by the completion strobe |
| irq_out | output | 1 | Interrupt to the processor |
| dev_reset | output | 1 | One-cycle reset pulse to the attached device |

## Verification
The assertions rely on three things about the inputs: that they hold defined values from time zero, that no more than one bus strobe is issued per cycle, and that `periph_irq` changes only between clock edges. The bench drives every input on the falling clock edge and sets all of them to zero before reset is released. It never raises read and write together. It keeps each interrupt edge apart from control writes, so the edge-after-write ordering is the only ordering in play.

// File: rtl/dma_regblk_pkg.sv
package dma_regblk_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_WORD = 4;
  localparam int SEL_W    = $clog2(NUM_WORD);

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_GP0  = 2'd2,
    SEL_GP1  = 2'd3
  } word_sel_e;

  localparam int BIT_PEND   = 0;
  localparam int BIT_IEN    = 4;
  localparam int BIT_DRAIN  = 6;
  localparam int BIT_DEVRST = 7;
  localparam int BIT_LOADED = 26;
  localparam int VER_LSB    = 28;
endpackage

// File: rtl/dma_ctrl_shaper.sv
module dma_ctrl_shaper
  import dma_regblk_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'hA
) (
  input  logic [WORD_W-1:0] wval,
  output logic [WORD_W-1:0] stored,
  output logic              rst_req
);
  localparam logic [WORD_W-1:0] VER_WORD = {VERSION, {VER_LSB{1'b0}}};
  localparam logic [WORD_W-1:0] LOW_MASK = {4'h0, {VER_LSB{1'b1}}};

  logic [WORD_W-1:0] adj;

  always_comb begin
    adj = wval;
    if (wval[BIT_DEVRST]) begin
      adj = wval;
    end else if (wval[BIT_DRAIN]) begin
      adj[BIT_DRAIN] = 1'b0;
    end else if (wval == '0) begin
      adj[BIT_DRAIN] = 1'b1;
    end
    stored  = (adj & LOW_MASK) | VER_WORD;
    rst_req = wval[BIT_DEVRST];
  end
endmodule

// File: rtl/dma_irq_track.sv
module dma_irq_track (
  input  logic clk,
  input  logic rst,
  input  logic periph_irq,
  input  logic ctrl_wr,
  input  logic ctrl_ien,
  output logic rise,
  output logic fall,
  output logic irq_o
);
  logic prev_q;
  logic irq_q;

  assign rise  = periph_irq & ~prev_q;
  assign fall  = ~periph_irq & prev_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= periph_irq;
      if (rise) begin
        irq_q <= 1'b1;
      end else if (fall) begin
        irq_q <= 1'b0;
      end else if (ctrl_wr && !ctrl_ien) begin
        irq_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_regblk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              done,
  input  logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] q,
  output logic              done_taken
);
  logic [WORD_W-1:0] q_r;

  assign done_taken = done & ~wr;
  assign q          = q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (wr) begin
      q_r <= wdata;
    end else if (done_taken) begin
      q_r <= q_r + WORD_W'(cnt);
    end
  end
endmodule

// File: rtl/dma_regblk.sv
module dma_regblk
  import dma_regblk_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter int         CNT_W   = 16,
  parameter logic [3:0] VERSION = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              periph_irq,
  input  logic              xfer_done,
  input  logic [CNT_W-1:0]  xfer_bytes,
  output logic              irq_out,
  output logic              dev_reset
);
  localparam int NUM_GP = NUM_WORD - 2;

  word_sel_e         sel;
  logic              wr_ctrl, wr_addr;
  logic [WORD_W-1:0] shaped, ctrl_q, ctrl_d, addr_q;
  logic              rst_req, rise, fall, done_taken;
  logic              rst_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] gp_q [NUM_GP];

  wire unused_addr = &{1'b0, bus_addr[ADDR_W-1:4], bus_addr[1:0]};

  assign sel     = word_sel_e'(bus_addr[3:2]);
  assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
  assign wr_addr = bus_wr && (sel == SEL_ADDR);

  dma_ctrl_shaper #(.VERSION(VERSION)) u_shape (
    .wval   (bus_wdata),
    .stored (shaped),
    .rst_req(rst_req)
  );

  dma_irq_track u_irq (
    .clk       (clk),
    .rst       (rst),
    .periph_irq(periph_irq),
    .ctrl_wr   (wr_ctrl),
    .ctrl_ien  (bus_wdata[BIT_IEN]),
    .rise      (rise),
    .fall      (fall),
    .irq_o     (irq_out)
  );

  dma_addr_reg #(.CNT_W(CNT_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .wr        (wr_addr),
    .wdata     (bus_wdata),
    .done      (xfer_done),
    .cnt       (xfer_bytes),
    .q         (addr_q),
    .done_taken(done_taken)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl)             ctrl_d = shaped;
    if (wr_addr)             ctrl_d[BIT_LOADED] = 1'b1;
    if (rise || done_taken)  ctrl_d[BIT_PEND] = 1'b1;
    if (fall)                ctrl_d[BIT_PEND] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= {VERSION, {VER_LSB{1'b0}}};
      rst_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      rst_q  <= wr_ctrl && rst_req;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_GP; g++) begin : g_gp
      always_ff @(posedge clk) begin
        if (rst) begin
          gp_q[g] <= '0;
        end else if (bus_wr && (sel == word_sel_e'(g + 2))) begin
          gp_q[g] <= bus_wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_CTRL: rdata_q <= ctrl_q;
        SEL_ADDR: rdata_q <= addr_q;
        SEL_GP0:  rdata_q <= gp_q[0];
        default:  rdata_q <= gp_q[1];
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign dev_reset = rst_q;
endmodule

// File: rtl/dma_regblk_chk.sv
module dma_regblk_chk #(
  parameter int         ADDR_W  = 8,
  parameter logic [3:0] VERSION = 4'hA
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              periph_irq,
  input logic              irq_out,
  input logic              dev_reset,
  input logic [31:0]       ctrl_q
);
  wire unused_chk = &{1'b0, bus_addr[ADDR_W-1:4], bus_addr[1:0],
                      bus_wdata[31:8], bus_wdata[6:0]};

  logic wr0_rst, wr1;
  assign wr0_rst = bus_wr && (bus_addr[3:2] == 2'd0) && bus_wdata[7];
  assign wr1     = bus_wr && (bus_addr[3:2] == 2'd1);

  // R3: the version nibble never changes
  a_r3_version_nibble: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[31:28] == VERSION);

  // R6: the device pulse follows a reset-bit control write
  a_r6_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
    wr0_rst |=> dev_reset);

  // R6: no pulse without such a write
  a_r6_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
    !wr0_rst |=> !dev_reset);

  // R8: an address write marks the channel loaded
  a_r8_loaded_flag: assert property (@(posedge clk) disable iff (rst)
    wr1 |=> ctrl_q[26]);

  // R9: rising request raises status and output
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(periph_irq) |=> (irq_out && ctrl_q[0]));

  // R9: falling request clears status and output
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(periph_irq) |=> (!irq_out && !ctrl_q[0]));
endmodule

bind dma_regblk dma_regblk_chk #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .periph_irq(periph_irq),
  .irq_out   (irq_out),
  .dev_reset (dev_reset),
  .ctrl_q    (ctrl_q)
);

// File: tb/sim_dma_regblk.sv
module sim_dma_regblk;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              periph_irq = 1'b0;
  logic              xfer_done = 1'b0;
  logic [CNT_W-1:0]  xfer_bytes = '0;
  logic              irq_out, dev_reset;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_regblk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_irq(periph_irq), .xfer_done(xfer_done), .xfer_bytes(xfer_bytes),
    .irq_out(irq_out), .dev_reset(dev_reset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic done_pulse(input logic [15:0] c);
    @(negedge clk);
    xfer_done = 1'b1; xfer_bytes = c;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  function automatic logic [31:0] shape(input logic [31:0] v);
    logic [31:0] a;
    a = v;
    if (v[7]) a = v;
    else if (v[6]) a[6] = 1'b0;
    else if (v == 32'h0) a = 32'h40;
    return (a & 32'h0FFF_FFFF) | 32'hA000_0000;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2, d, w1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 dev_reset", {31'b0, dev_reset}, 32'h0);
    bus_read(8'h00, r); chk("R1 word0", r, 32'hA000_0000);
    bus_read(8'h04, r); chk("R1 word1", r, 32'h0);
    bus_read(8'h08, r); chk("R1 word2", r, 32'h0);
    bus_read(8'h0C, r); chk("R1 word3", r, 32'h0);

    // R12 reads: repeatable, value held with no strobe
    bus_read(8'h00, r);
    bus_read(8'h00, r2); chk("R12 repeat read", r2, r);
    @(negedge clk); @(negedge clk);
    chk("R12 hold rdata", bus_rdata, r);

    // R3 R4 R5 R6 control write sweep
    for (int i = 0; i < 300; i++) begin
      d = (i == 0) ? 32'h0 : {i[7:0] ^ 8'h3C, i[7:0], 8'h00, i[7:0]};
      bus_write(8'h00, d);
      chk("R6 pulse", {31'b0, dev_reset}, {31'b0, d[7]});
      @(negedge clk);
      chk("R6 pulse width", {31'b0, dev_reset}, 32'h0);
      bus_read(8'h00, r);
      chk(d == 0 ? "R5 zero write" : (d[7] ? "R3 R6 stored" : "R3 R4 stored"), r, shape(d));
    end

    // R8 loaded flag
    bus_write(8'h00, 32'h10);
    bus_write(8'h04, 32'h1234_5678);
    bus_read(8'h04, r); chk("R8 word1", r, 32'h1234_5678);
    bus_read(8'h00, r); chk("R8 loaded", r, 32'hA400_0010);

    // R2 aliasing through upper and lower address bits
    bus_write(8'hF4, 32'hCAFE_0001);
    bus_read(8'h04, r); chk("R2 alias word1", r, 32'hCAFE_0001);
    bus_write(8'hE8, 32'h0BAD_F00D);
    bus_read(8'h3B, r); chk("R2 alias word2", r, 32'h0BAD_F00D);

    // R13 general words independent
    for (int k = 0; k < 8; k++) begin
      bus_write(8'h08, 32'h1111_1111 * k);
      bus_write(8'h0D, ~(32'h0101_0101 * k));
      bus_read(8'h08, r); chk("R13 word2", r, 32'h1111_1111 * k);
      bus_read(8'h0C, r); chk("R13 word3", r, ~(32'h0101_0101 * k));
      bus_read(8'h04, r); chk("R13 word1 untouched", r, 32'hCAFE_0001);
    end

    // R9 R7 interrupt path
    bus_write(8'h00, 32'h10);
    @(negedge clk); periph_irq = 1'b1;
    @(negedge clk);
    chk("R9 rise irq_out", {31'b0, irq_out}, 32'h1);
    bus_read(8'h00, r); chk("R9 rise bit0", r, 32'hA000_0011);
    bus_write(8'h00, 32'h11);
    chk("R7 ien set keeps irq", {31'b0, irq_out}, 32'h1);
    bus_write(8'h00, 32'h01);
    chk("R7 ien clear drops irq", {31'b0, irq_out}, 32'h0);
    bus_read(8'h00, r); chk("R7 stored", r, 32'hA000_0001);
    @(negedge clk); periph_irq = 1'b0;
    @(negedge clk);
    chk("R9 fall irq_out", {31'b0, irq_out}, 32'h0);
    bus_read(8'h00, r); chk("R9 fall bit0", r, 32'hA000_0000);
    @(negedge clk); periph_irq = 1'b1;
    @(negedge clk);
    chk("R9 rise again", {31'b0, irq_out}, 32'h1);
    @(negedge clk); periph_irq = 1'b0;
    @(negedge clk);
    chk("R9 fall again", {31'b0, irq_out}, 32'h0);

    // R10 transfer done increments
    w1 = 32'h0000_1000;
    bus_write(8'h04, w1);
    bus_write(8'h00, 32'h10);
    for (int k = 0; k < 40; k++) begin
      d = ((k * k * 37) + 1) & 32'hFFFF;
      done_pulse(d[15:0]);
      w1 = w1 + d;
      chk("R10 irq unchanged", {31'b0, irq_out}, 32'h0);
      bus_read(8'h04, r); chk("R10 word1 advance", r, w1);
    end
    bus_read(8'h00, r); chk("R10 bit0 set", r, 32'hA000_0011);
    bus_write(8'h04, 32'hFFFF_FFF0);
    done_pulse(16'h0020);
    bus_read(8'h04, r); chk("R10 wrap", r, 32'h0000_0010);

    // R11 same-cycle write beats strobe
    bus_write(8'h00, 32'h10);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h5555_AAAA;
    xfer_done = 1'b1; xfer_bytes = 16'd100;
    @(negedge clk);
    bus_wr = 1'b0; xfer_done = 1'b0;
    bus_read(8'h04, r); chk("R11 word1 written", r, 32'h5555_AAAA);
    bus_read(8'h00, r); chk("R11 bit0 untouched", r, 32'hA400_0010);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule